// File: doc/BRIEF.md
# Tri-Port Pixel Cache with Per-Byte Dirty Tags

This block is a small on-chip pixel cache placed between a wide memory bus and a pixel arithmetic unit. It holds eight blocks of 256 bits, and each block is eight 32-bit words. The cache has three ports, and all three can work in the same cycle. A block port loads whole blocks from the wide bus and returns whole blocks to it. A 32-bit word read port and a 32-bit word write port serve the pixel unit.

Each byte of storage has its own dirty bit. A block load clears the dirty bits of that block. A word write marks the bytes it enables as dirty. When a block is written back, the cache returns the block data and a 256-bit bit-enable vector. A bit is enabled only if its byte is dirty and the matching bit of a 32-bit plane mask is set. The mask covers one word and is repeated for all eight words of the block. The memory therefore only changes the bits that were really modified and that belong to the enabled planes. The choice of which block to evict or load is made outside the block.

Top module: `pixcache_top`

## Requirements
- R1: After reset, `rd_valid`, `wb_done` and `wb_bit_en` are 0, `fill_ready` is 1, every dirty tag is clear (a writeback returns an all-zero bit enable), and the plane mask is all ones.
- R2: A 6-bit word address selects the block with bits [5:3] and the word with bits [2:0]. Word w of a block occupies bits [32w+31:32w] of the 256-bit fill and writeback data.
- R3: Word write enable bit i controls byte i, which is bits [8i+7:8i] of the word. Bytes whose enable is 0 keep their previous value, and an all-zero enable changes nothing.
- R4: A word read returns the word's contents as they were before the request edge, one cycle later, with `rd_valid` high for exactly that cycle.
- R5: A word write sets the dirty bit of each byte it enables. Byte k of word w is dirty bit 4w+k of the block.
- R6: An accepted block fill replaces the whole block and clears all 32 dirty bits of that block.
- R7: One cycle after `wb_valid`, `wb_done` is high. At the same time `wb_data` holds the block contents and bit j of `wb_bit_en` equals dirty bit j/8 AND plane-mask bit j mod 32.
- R8: `pm_we` loads the plane mask at the clock edge. A writeback requested in the same cycle still uses the previous mask.
- R9: A writeback request takes the block port. While `wb_valid` is high, `fill_ready` is 0 and an offered fill has no effect.
- R10: A writeback leaves the dirty tags unchanged, so repeating it returns the same bit enable.
- R11: A fill, a word write and a word read that address different cells all take effect in the same cycle. If a fill and a word write hit the same block, the enabled bytes of the word write win and only those bytes end up dirty.
- R12: If a read and a write hit the same word in one cycle, the write succeeds. The read data of that cycle is unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Block load request |
| fill_ready | output | 1 | Block port free for a load |
| fill_blk | input | 3 | Block index to load |
| fill_data | input | 256 | Block load data |
| wb_valid | input | 1 | Writeback request |
| wb_blk | input | 3 | Block index to write back |
| wb_done | output | 1 | Writeback result valid |
| wb_data | output | 256 | Writeback block data |
| wb_bit_en | output | 256 | Per-bit write enable for the memory |
| ww_en | input | 1 | Word write strobe |
| ww_addr | input | 6 | Word write address |
| ww_be | input | 4 | Word write byte enables |
| ww_data | input | 32 | Word write data |
| rd_en | input | 1 | Word read strobe |
| rd_addr | input | 6 | Word read address |
| rd_valid | output | 1 | Word read data valid |
| rd_data | output | 32 | Word read data |
| pm_we | input | 1 | Plane mask load strobe |
| pm_data | input | 32 | Plane mask value |

## Verification
Word writes, fills and plane-mask loads take effect at the request edge. The bench therefore checks their effect through a later read or writeback. Reads and writebacks return their results one edge after the request. Every check samples 1 ns after the edge that follows the request, which keeps samples away from the active edge. An independent model in the bench holds the data, the dirty tags and the mask. Every writeback over a long pseudo-random sequence is compared with that model. The read data of a same-word collision is never checked.

// File: rtl/pixcache_pkg.sv
package pixcache_pkg;
    parameter int BLOCKS = 8;
    parameter int WORDS  = 8;
    parameter int WORD_W = 32;

    localparam int BYTE_W    = 8;
    localparam int BYTES     = WORD_W / BYTE_W;
    localparam int BLK_W     = WORDS * WORD_W;
    localparam int BLK_BYTES = BLK_W / BYTE_W;
    localparam int BA_W      = $clog2(BLOCKS);
    localparam int WA_W      = $clog2(WORDS);
    localparam int ADDR_W    = BA_W + WA_W;

    typedef logic [BA_W-1:0]      blk_idx_t;
    typedef logic [WA_W-1:0]      word_idx_t;
    typedef logic [BLK_BYTES-1:0] dirty_t;

    typedef struct packed {
        logic               en;
        blk_idx_t           blk;
        word_idx_t          word;
        logic [BYTES-1:0]   be;
        logic [WORD_W-1:0]  data;
    } word_wr_t;

    typedef struct packed {
        logic               en;
        blk_idx_t           blk;
        word_idx_t          word;
    } word_rd_t;

    function automatic logic [BLK_W-1:0] spread_dirty(input dirty_t t);
        logic [BLK_W-1:0] v;
        for (int i = 0; i < BLK_BYTES; i++) v[i*BYTE_W +: BYTE_W] = {BYTE_W{t[i]}};
        return v;
    endfunction

    function automatic logic [BLK_W-1:0] tile_mask(input logic [WORD_W-1:0] m);
        return {WORDS{m}};
    endfunction
endpackage

// File: rtl/pixcache_data.sv
module pixcache_data
    import pixcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  word_wr_t          ww,
    input  logic              fill_en,
    input  blk_idx_t          fill_blk,
    input  logic [BLK_W-1:0]  fill_data,
    input  word_rd_t          rd,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  blk_idx_t          wb_blk,
    output logic [BLK_W-1:0]  wb_row
);
    logic [BLK_W-1:0] rows [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        logic [BLK_W-1:0] row_q;
        // fill first, word write bytes overwrite afterwards
        always_ff @(posedge clk) begin
            if (fill_en && fill_blk == blk_idx_t'(b))
                row_q <= fill_data;
            if (ww.en && ww.blk == blk_idx_t'(b)) begin
                for (int k = 0; k < BYTES; k++) begin
                    if (ww.be[k])
                        row_q[int'(ww.word)*WORD_W + k*BYTE_W +: BYTE_W] <= ww.data[k*BYTE_W +: BYTE_W];
                end
            end
        end
        assign rows[b] = row_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd.en;
            if (rd.en)
                rd_data <= rows[rd.blk][int'(rd.word)*WORD_W +: WORD_W];
        end
    end

    assign wb_row = rows[wb_blk];
endmodule

// File: rtl/pixcache_tags.sv
module pixcache_tags
    import pixcache_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fill_en,
    input  blk_idx_t                fill_blk,
    input  word_wr_t                ww,
    output logic [BLOCKS-1:0][BLK_BYTES-1:0] tags
);
    for (genvar b = 0; b < BLOCKS; b++) begin : g_tag
        dirty_t tag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q <= '0;
            end else begin
                if (fill_en && fill_blk == blk_idx_t'(b))
                    tag_q <= '0;
                if (ww.en && ww.blk == blk_idx_t'(b)) begin
                    for (int k = 0; k < BYTES; k++) begin
                        if (ww.be[k]) tag_q[int'(ww.word)*BYTES + k] <= 1'b1;
                    end
                end
            end
        end
        assign tags[b] = tag_q;
    end
endmodule

// File: rtl/pixcache_wbgen.sv
module pixcache_wbgen
    import pixcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pm_we,
    input  logic [WORD_W-1:0] pm_data,
    output logic [WORD_W-1:0] pm_q,
    input  logic              wb_fire,
    input  logic [BLK_W-1:0]  row,
    input  dirty_t            tag,
    output logic              wb_done,
    output logic [BLK_W-1:0]  wb_data,
    output logic [BLK_W-1:0]  wb_bit_en
);
    logic [BLK_W-1:0] en_next;

    always_comb en_next = spread_dirty(tag) & tile_mask(pm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_q      <= '1;
            wb_done   <= 1'b0;
            wb_data   <= '0;
            wb_bit_en <= '0;
        end else begin
            if (pm_we) pm_q <= pm_data;
            wb_done <= wb_fire;
            if (wb_fire) begin
                wb_data   <= row;
                wb_bit_en <= en_next;
            end
        end
    end
endmodule

// File: rtl/pixcache_top.sv
module pixcache_top
    import pixcache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [BA_W-1:0]   fill_blk,
    input  logic [BLK_W-1:0]  fill_data,
    input  logic              wb_valid,
    input  logic [BA_W-1:0]   wb_blk,
    output logic              wb_done,
    output logic [BLK_W-1:0]  wb_data,
    output logic [BLK_W-1:0]  wb_bit_en,
    input  logic              ww_en,
    input  logic [ADDR_W-1:0] ww_addr,
    input  logic [BYTES-1:0]  ww_be,
    input  logic [WORD_W-1:0] ww_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pm_we,
    input  logic [WORD_W-1:0] pm_data
);
    word_wr_t                          ww;
    word_rd_t                          rd;
    logic                              fill_fire;
    logic [BLK_W-1:0]                  wb_row;
    logic [BLOCKS-1:0][BLK_BYTES-1:0]  tag_all;
    logic [WORD_W-1:0]                 pm_q;

    // the block port serves one transfer per cycle; writeback has priority
    assign fill_ready = !wb_valid;
    assign fill_fire  = fill_valid && fill_ready;

    always_comb begin
        ww.en   = ww_en;
        ww.blk  = ww_addr[ADDR_W-1:WA_W];
        ww.word = ww_addr[WA_W-1:0];
        ww.be   = ww_be;
        ww.data = ww_data;
        rd.en   = rd_en;
        rd.blk  = rd_addr[ADDR_W-1:WA_W];
        rd.word = rd_addr[WA_W-1:0];
    end

    pixcache_data u_data (
        .clk(clk), .rst(rst), .ww(ww),
        .fill_en(fill_fire), .fill_blk(fill_blk), .fill_data(fill_data),
        .rd(rd), .rd_valid(rd_valid), .rd_data(rd_data),
        .wb_blk(wb_blk), .wb_row(wb_row)
    );

    pixcache_tags u_tags (
        .clk(clk), .rst(rst), .fill_en(fill_fire), .fill_blk(fill_blk),
        .ww(ww), .tags(tag_all)
    );

    pixcache_wbgen u_wbgen (
        .clk(clk), .rst(rst), .pm_we(pm_we), .pm_data(pm_data), .pm_q(pm_q),
        .wb_fire(wb_valid), .row(wb_row), .tag(tag_all[wb_blk]),
        .wb_done(wb_done), .wb_data(wb_data), .wb_bit_en(wb_bit_en)
    );
endmodule

// File: rtl/pixcache_checker.sv
module pixcache_checker
    import pixcache_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic                             fill_fire,
    input logic [BA_W-1:0]                  fill_blk,
    input logic                             ww_en,
    input logic [ADDR_W-1:0]                ww_addr,
    input logic [BYTES-1:0]                 ww_be,
    input logic [BLOCKS-1:0][BLK_BYTES-1:0] tag_all,
    input logic [WORD_W-1:0]                pm_q,
    input logic                             wb_valid,
    input logic                             wb_done,
    input logic [BLK_W-1:0]                 wb_bit_en,
    input logic                             rd_en,
    input logic                             rd_valid
);
    logic              p_ww;
    blk_idx_t          p_blk;
    word_idx_t         p_word;
    logic [BYTES-1:0]  p_be;
    logic              p_fill;
    blk_idx_t          p_fblk;
    logic [WORD_W-1:0] p_pm;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_ww <= 1'b0; p_blk <= '0; p_word <= '0; p_be <= '0;
            p_fill <= 1'b0; p_fblk <= '0; p_pm <= '1;
        end else begin
            p_ww   <= ww_en;
            p_blk  <= ww_addr[ADDR_W-1:WA_W];
            p_word <= ww_addr[WA_W-1:0];
            p_be   <= ww_be;
            p_fill <= fill_fire && !(ww_en && ww_addr[ADDR_W-1:WA_W] == fill_blk);
            p_fblk <= fill_blk;
            p_pm   <= pm_q;
        end
    end

    assert_fill_clears_R6: assert property (@(posedge clk) disable iff (rst)
        p_fill |-> (tag_all[p_fblk] == '0));

    assert_write_marks_R5: assert property (@(posedge clk) disable iff (rst)
        p_ww |-> ((tag_all[p_blk][int'(p_word)*BYTES +: BYTES] & p_be) == p_be));

    assert_mask_gates_R7: assert property (@(posedge clk) disable iff (rst)
        wb_done |-> ((wb_bit_en & ~tile_mask(p_pm)) == '0));

    assert_wb_latency_R7: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> wb_done);

    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_rd_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    assert_wb_keeps_tags_R10: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !fill_fire && !ww_en) |=> $stable(tag_all));
endmodule

bind pixcache_top pixcache_checker u_checker (
    .clk(clk), .rst(rst), .fill_fire(fill_fire), .fill_blk(fill_blk),
    .ww_en(ww_en), .ww_addr(ww_addr), .ww_be(ww_be), .tag_all(tag_all),
    .pm_q(pm_q), .wb_valid(wb_valid), .wb_done(wb_done), .wb_bit_en(wb_bit_en),
    .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/pixcache_top_bench.sv
`timescale 1ns/1ps
module pixcache_top_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         fill_valid = 0, fill_ready;
    logic [2:0]   fill_blk = 0;
    logic [255:0] fill_data = 0;
    logic         wb_valid = 0, wb_done;
    logic [2:0]   wb_blk = 0;
    logic [255:0] wb_data, wb_bit_en;
    logic         ww_en = 0;
    logic [5:0]   ww_addr = 0;
    logic [3:0]   ww_be = 0;
    logic [31:0]  ww_data = 0;
    logic         rd_en = 0;
    logic [5:0]   rd_addr = 0;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic         pm_we = 0;
    logic [31:0]  pm_data = 0;

    always #2.5 clk = ~clk;

    pixcache_top u_pixcache_top (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [255:0] ref_row [8];
    logic [31:0]  ref_tag [8];
    logic [31:0]  ref_pm;
    logic [31:0]  seed = 32'h1234ABCD;

    // {addr, byte enables, data}
    localparam logic [41:0] VEC [12] = '{
        {6'o00, 4'hF, 32'h11223344}, {6'o07, 4'h1, 32'hAABBCCDD},
        {6'o12, 4'h6, 32'h55667788}, {6'o27, 4'h8, 32'hDEADBEEF},
        {6'o31, 4'hA, 32'h01020304}, {6'o45, 4'h3, 32'hCAFEF00D},
        {6'o56, 4'h4, 32'h13579BDF}, {6'o77, 4'hF, 32'hFFFFFFFF},
        {6'o00, 4'h2, 32'h0BAD0BAD}, {6'o63, 4'h0, 32'h12345678},
        {6'o71, 4'hC, 32'h87654321}, {6'o12, 4'h9, 32'h24681357}
    };

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [255:0] exp_en(input int b);
        logic [255:0] e;
        for (int j = 0; j < 256; j++) e[j] = ref_tag[b][j/8] & ref_pm[j%32];
        return e;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ref_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        for (int k = 0; k < 4; k++) if (be[k]) begin
            ref_row[a[5:3]][a[2:0]*32 + k*8 +: 8] = d[k*8 +: 8];
            ref_tag[a[5:3]][a[2:0]*4 + k] = 1'b1;
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        ww_en = 1; ww_addr = a; ww_be = be; ww_data = d;
        tick();
        ww_en = 0;
        ref_write(a, be, d);
    endtask

    task automatic do_read(input string req, input logic [5:0] a);
        rd_en = 1; rd_addr = a;
        tick();
        rd_en = 0;
        chk(req, {255'd0, rd_valid}, 256'd1);
        chk(req, {224'd0, rd_data}, {224'd0, ref_row[a[5:3]][a[2:0]*32 +: 32]});
    endtask

    task automatic do_fill(input logic [2:0] b, input logic [255:0] d);
        fill_valid = 1; fill_blk = b; fill_data = d;
        tick();
        fill_valid = 0;
        ref_row[b] = d;
        ref_tag[b] = '0;
    endtask

    task automatic do_wb(input string req, input logic [2:0] b);
        wb_valid = 1; wb_blk = b;
        tick();
        wb_valid = 0;
        chk(req, {255'd0, wb_done}, 256'd1);
        chk(req, wb_data, ref_row[b]);
        chk(req, wb_bit_en, exp_en(b));
    endtask

    task automatic do_pm(input logic [31:0] m);
        pm_we = 1; pm_data = m;
        tick();
        pm_we = 0;
        ref_pm = m;
    endtask

    function automatic logic [255:0] rnd_block();
        logic [255:0] v;
        for (int w = 0; w < 8; w++) v[w*32 +: 32] = rnd();
        return v;
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 8; b++) ref_tag[b] = '0;
        ref_pm = '1;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        chk("R1 rd_valid", {255'd0, rd_valid}, 256'd0);
        chk("R1 wb_done", {255'd0, wb_done}, 256'd0);
        chk("R1 wb_bit_en", wb_bit_en, 256'd0);
        chk("R1 fill_ready", {255'd0, fill_ready}, 256'd1);
        wb_valid = 1; wb_blk = 3'd4;
        tick();
        wb_valid = 0;
        chk("R1 clean tags", wb_bit_en, 256'd0);
        // R1: mask all ones after reset (one dirty byte passes fully)
        do_fill(3'd4, rnd_block());
        do_write(6'o40, 4'h1, 32'h000000A5);
        do_wb("R1 mask ones", 3'd4);

        // R6: fill every block, tags cleared
        for (int b = 0; b < 8; b++) begin
            logic [255:0] v;
            for (int w = 0; w < 8; w++) v[w*32 +: 32] = {8'hB0 | 8'(b), 16'h0000, 8'(w)};
            do_fill(3'(b), v);
        end
        do_wb("R6 fill clears", 3'd4);
        // R2: word 5 of block 6 lies in fill bits [191:160]
        rd_en = 1; rd_addr = 6'o65;
        tick();
        rd_en = 0;
        chk("R2 word position", {224'd0, rd_data}, {224'd0, 32'hB6000005});

        // R3/R5: vector table
        for (int i = 0; i < 12; i++) begin
            do_write(VEC[i][41:36], VEC[i][35:32], VEC[i][31:0]);
            do_read("R3 byte enables", VEC[i][41:36]);
        end
        do_read("R3 no-enable write", 6'o63);
        do_pm(32'hF0F0FF00);
        for (int b = 0; b < 8; b++) do_wb("R5 dirty after writes", 3'(b));

        // R4: read returns pre-edge data
        do_read("R4 read", 6'o12);

        // R8: mask load same cycle as writeback uses old mask
        pm_we = 1; pm_data = 32'h0000FFFF; wb_valid = 1; wb_blk = 3'd0;
        tick();
        pm_we = 0; wb_valid = 0;
        chk("R8 old mask", wb_bit_en, exp_en(0));
        ref_pm = 32'h0000FFFF;
        do_wb("R8 new mask", 3'd0);

        // R9: writeback blocks a fill
        wb_valid = 1; wb_blk = 3'd7; fill_valid = 1; fill_blk = 3'd1; fill_data = {64{4'h5}};
        #1 chk("R9 fill_ready low", {255'd0, fill_ready}, 256'd0);
        tick();
        wb_valid = 0; fill_valid = 0;
        chk("R9 wb data", wb_data, ref_row[7]);
        do_read("R9 fill ignored", 6'o10);
        do_wb("R9 tags unchanged", 3'd1);

        // R10: repeated writeback
        do_wb("R10 first", 3'd5);
        do_wb("R10 repeat", 3'd5);

        // R11: concurrent ports on different cells
        fill_valid = 1; fill_blk = 3'd2; fill_data = rnd_block();
        ww_en = 1; ww_addr = 6'o51; ww_be = 4'hF; ww_data = 32'h5A5A1234;
        rd_en = 1; rd_addr = 6'o13;
        tick();
        fill_valid = 0; ww_en = 0; rd_en = 0;
        chk("R11 concurrent read", {224'd0, rd_data}, {224'd0, ref_row[1][3*32 +: 32]});
        ref_row[2] = fill_data; ref_tag[2] = '0;
        ref_write(6'o51, 4'hF, 32'h5A5A1234);
        do_read("R11 concurrent fill", 6'o20);
        do_read("R11 concurrent write", 6'o51);
        // fill and word write to the same block
        fill_valid = 1; fill_blk = 3'd3; fill_data = rnd_block();
        ww_en = 1; ww_addr = 6'o32; ww_be = 4'h5; ww_data = 32'hC3C3C3C3;
        tick();
        fill_valid = 0; ww_en = 0;
        ref_row[3] = fill_data; ref_tag[3] = '0;
        ref_write(6'o32, 4'h5, 32'hC3C3C3C3);
        do_pm(32'hFFFFFFFF);
        do_wb("R11 write wins over fill", 3'd3);

        // R12: read/write collision, write succeeds
        ww_en = 1; ww_addr = 6'o66; ww_be = 4'hF; ww_data = 32'h0F1E2D3C;
        rd_en = 1; rd_addr = 6'o66;
        tick();
        ww_en = 0; rd_en = 0;
        ref_write(6'o66, 4'hF, 32'h0F1E2D3C);
        do_read("R12 collision write", 6'o66);

        // R7: random sequences against the model
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = rnd();
            case (r[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: do_write(r[8:3], r[12:9], rnd());
                3'd4: do_fill(r[5:3], rnd_block());
                3'd5: do_pm(rnd());
                3'd6: do_wb("R7 random writeback", r[5:3]);
                default: do_read("R4 random read", r[8:3]);
            endcase
        end
        for (int b = 0; b < 8; b++) do_wb("R7 final writeback", 3'(b));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule